// File: doc/BRIEF.md
# Burst-of-Two Common-I/O DDR SRAM Device Model

A synthesizable, memory-side model of a double-data-rate SRAM with a shared data bus and fixed two-beat bursts. It is meant to sit across from a memory controller in a self-checking test. Commands are sampled on the rising clock edge, write data arrives late (one cycle after its command), and read data comes back through a short pipeline. Every clock cycle has two half-cycle data slots: lane A is the half that follows the rising edge, and lane B is the half that follows the falling edge. Each lane has its own data and output-enable ports.

A load-enable held high inserts an idle (deselect) slot. An idle slot passes through the same pipeline as a read, so any burst already in flight finishes before the output enables drop. If the model would drive the bus in a half-cycle where the controller is due to drive write data, it raises a protocol-error flag.

Top module: `b2s_sram_model`

## Requirements
- R1: On each rising edge, `load_ni`=0 with `is_rd_i`=1 loads a read, `load_ni`=0 with `is_rd_i`=0 loads a write, and `load_ni`=1 loads nothing.
- R2: Every loaded read produces exactly two beats: one on lane B in one cycle, then one on lane A in the next cycle.
- R3: For a write loaded on edge n, the data on `wd_a_i` and `wd_b_i` is sampled on edge n+1 and stored as the two beats of the burst.
- R4: For a read loaded on edge n, `oe_b_o` is high in the cycle after edge n+1, and `oe_a_o` is high in the cycle after edge n+2.
- R5: An idle slot or a write loads no read beat: two edges after such a slot, `oe_b_o` is low.
- R6: The first beat of a burst uses the loaded address. The second beat uses the same address with bit 0 inverted.
- R7: A lane whose output enable is low drives zero on its data port.
- R8: Reads loaded on consecutive edges produce an unbroken stream of beats, with no gap slots between bursts.
- R9: `err_o` is high in any cycle where a loaded write awaits its data (the cycle after the write edge) and either output enable is high.
- R10: While `rst_ni` is low and after reset, both output enables and `err_o` are low.
- R11: A read loaded on the edge right after a write to the same address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock; rising edge samples commands and write data |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_ni | input | 1 | Active-low command load enable |
| is_rd_i | input | 1 | 1 selects read, 0 selects write |
| addr_i | input | ADDR_W | Burst start address |
| wd_a_i | input | DATA_W | Write beat one (loaded address) |
| wd_b_i | input | DATA_W | Write beat two (address with bit 0 inverted) |
| q_a_o | output | DATA_W | Read data for the lane A half-cycle |
| q_b_o | output | DATA_W | Read data for the lane B half-cycle |
| oe_a_o | output | 1 | Model drives lane A |
| oe_b_o | output | 1 | Model drives lane B |
| err_o | output | 1 | Bus contention between read output and pending write data |

## Verification
Read output and write data intake can land in the same cycle. This happens when a write is loaded on the edge directly after a read, which collides on lane B. It also happens when a write is loaded one idle slot after a read, which collides on lane A. The bench provokes both cases, plus a write loaded two idle slots after a read, which must not collide.

The scoreboard expects `err_o` high exactly in the cycles where it predicts both a pending write and an expected read beat. In every other cycle it expects `err_o` low. Alongside this, the scoreboard checks the lane data and the enables on every cycle.

// File: rtl/b2s_pkg.sv
package b2s_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_WR   = 2'd2
  } cmd_e;
endpackage

// File: rtl/b2s_cmd_dec.sv
module b2s_cmd_dec
  import b2s_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_ni,
  input  logic              is_rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output cmd_e              cmd_o,
  output logic [ADDR_W-1:0] addr_o
);
  cmd_e cmd_d;

  always_comb begin
    if (load_ni)      cmd_d = CMD_IDLE;
    else if (is_rd_i) cmd_d = CMD_RD;
    else              cmd_d = CMD_WR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o  <= CMD_IDLE;
      addr_o <= '0;
    end else begin
      cmd_o  <= cmd_d;
      if (!load_ni) addr_o <= addr_i;
    end
  end
endmodule

// File: rtl/b2s_store.sv
module b2s_store #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wd0_i,
  input  logic [DATA_W-1:0] wd1_i,
  output logic [DATA_W-1:0] rd0_o,
  output logic [DATA_W-1:0] rd1_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [ADDR_W-1:0] addr_pair;

  // second beat: same word pair, other half
  assign addr_pair = {addr_i[ADDR_W-1:1], ~addr_i[0]};

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      mem_q[addr_i]    <= wd0_i;
      mem_q[addr_pair] <= wd1_i;
    end
  end

  assign rd0_o = mem_q[addr_i];
  assign rd1_o = mem_q[addr_pair];
endmodule

// File: rtl/b2s_rd_pipe.sv
module b2s_rd_pipe #(
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] rd0_i,
  input  logic [DATA_W-1:0] rd1_i,
  output logic [DATA_W-1:0] q_a_o,
  output logic [DATA_W-1:0] q_b_o,
  output logic              oe_a_o,
  output logic              oe_b_o
);
  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_b_o <= 1'b0;
      q_b_o  <= '0;
      hold_q <= '0;
      oe_a_o <= 1'b0;
      q_a_o  <= '0;
    end else begin
      oe_b_o <= rd_i;
      q_b_o  <= rd_i ? rd0_i : '0;
      hold_q <= rd_i ? rd1_i : '0;
      oe_a_o <= oe_b_o;
      q_a_o  <= oe_b_o ? hold_q : '0;
    end
  end
endmodule

// File: rtl/b2s_sram_model.sv
module b2s_sram_model
  import b2s_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_ni,
  input  logic              is_rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wd_a_i,
  input  logic [DATA_W-1:0] wd_b_i,
  output logic [DATA_W-1:0] q_a_o,
  output logic [DATA_W-1:0] q_b_o,
  output logic              oe_a_o,
  output logic              oe_b_o,
  output logic              err_o
);
  cmd_e              cmd_s0;
  logic [ADDR_W-1:0] addr_s0;
  logic [DATA_W-1:0] rd0, rd1;
  logic              wr_pend, rd_s0;

  b2s_cmd_dec #(.ADDR_W(ADDR_W)) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_ni (load_ni),
    .is_rd_i (is_rd_i),
    .addr_i  (addr_i),
    .cmd_o   (cmd_s0),
    .addr_o  (addr_s0)
  );

  assign wr_pend = (cmd_s0 == CMD_WR);
  assign rd_s0   = (cmd_s0 == CMD_RD);

  // late write: data present during the cycle after the command
  b2s_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_i  (clk_i),
    .we_i   (wr_pend),
    .addr_i (addr_s0),
    .wd0_i  (wd_a_i),
    .wd1_i  (wd_b_i),
    .rd0_o  (rd0),
    .rd1_o  (rd1)
  );

  b2s_rd_pipe #(.DATA_W(DATA_W)) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (rd_s0),
    .rd0_i  (rd0),
    .rd1_i  (rd1),
    .q_a_o  (q_a_o),
    .q_b_o  (q_b_o),
    .oe_a_o (oe_a_o),
    .oe_b_o (oe_b_o)
  );

  assign err_o = wr_pend & (oe_a_o | oe_b_o);
endmodule

// File: rtl/b2s_sram_model_chk.sv
module b2s_sram_model_chk #(
  parameter int DATA_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_ni,
  input logic              is_rd_i,
  input logic [DATA_W-1:0] q_a_o,
  input logic [DATA_W-1:0] q_b_o,
  input logic              oe_a_o,
  input logic              oe_b_o,
  input logic              err_o
);
  AST_RD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_ni && is_rd_i) |=> ##1 oe_b_o); // R4

  AST_SECOND_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_b_o |=> oe_a_o); // R2

  AST_NO_READ_NO_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni || !is_rd_i) |=> ##1 !oe_b_o); // R5

  AST_RELEASE_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_a_o |-> (q_a_o == '0)); // R7

  AST_RELEASE_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_b_o |-> (q_b_o == '0)); // R7

  AST_ERR_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(!load_ni && !is_rd_i)); // R9

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!oe_a_o && !oe_b_o && !err_o); // R10
    end
  end
endmodule

bind b2s_sram_model b2s_sram_model_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .load_ni (load_ni),
  .is_rd_i (is_rd_i),
  .q_a_o   (q_a_o),
  .q_b_o   (q_b_o),
  .oe_a_o  (oe_a_o),
  .oe_b_o  (oe_b_o),
  .err_o   (err_o)
);

// File: tb/b2s_sram_model_tb_top.sv
`timescale 1ns/1ps
module b2s_sram_model_tb_top;
  localparam int AW = 6;
  localparam int DW = 9;
  localparam real CLK_P = 8.0;

  typedef struct {
    int          cyc;
    logic [DW-1:0] d;
    string       req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          load_ni = 1'b1;
  logic          is_rd_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wd_a_i = '0;
  logic [DW-1:0] wd_b_i = '0;
  logic [DW-1:0] q_a_o, q_b_o;
  logic          oe_a_o, oe_b_o, err_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit run = 0;
  bit done = 0;

  exp_t qa[$];
  exp_t qb[$];
  bit   wr_at [int];
  logic [DW-1:0] ref_mem [1<<AW];
  logic [DW-1:0] pend_a = '0, pend_b = '0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  b2s_sram_model #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk_i (clk), .rst_ni (rst_ni), .load_ni (load_ni), .is_rd_i (is_rd_i),
    .addr_i (addr_i), .wd_a_i (wd_a_i), .wd_b_i (wd_b_i),
    .q_a_o (q_a_o), .q_b_o (q_b_o), .oe_a_o (oe_a_o), .oe_b_o (oe_b_o),
    .err_o (err_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s cyc=%0d actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // one cycle of stimulus; kind: 0 idle, 1 read, 2 write
  task automatic step(input int kind, input logic [AW-1:0] a,
                      input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                      input string req);
    int c;
    @(posedge clk);
    #1;
    c = cyc;
    wd_a_i = pend_a;
    wd_b_i = pend_b;
    pend_a = '0;
    pend_b = '0;
    load_ni = (kind == 0);
    is_rd_i = (kind == 1);
    addr_i  = a;
    if (kind == 1) begin
      qb.push_back('{c + 2, ref_mem[a], req});
      qa.push_back('{c + 3, ref_mem[a ^ 6'd1], req});
    end else if (kind == 2) begin
      ref_mem[a] = d0;
      ref_mem[a ^ 6'd1] = d1;
      pend_a = d0;
      pend_b = d1;
      wr_at[c + 1] = 1'b1;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    bit eb, ea, ee;
    if (run) begin
      eb = (qb.size() > 0) && (qb[0].cyc == cyc);
      ea = (qa.size() > 0) && (qa[0].cyc == cyc);
      check(oe_b_o == eb, eb ? qb[0].req : "R5", oe_b_o, eb);
      check(oe_a_o == ea, ea ? "R2" : "R5", oe_a_o, ea);
      if (eb) begin
        check(q_b_o == qb[0].d, qb[0].req, q_b_o, qb[0].d);
        void'(qb.pop_front());
      end else check(q_b_o == '0, "R7", q_b_o, 0);
      if (ea) begin
        check(q_a_o == qa[0].d, "R6", q_a_o, qa[0].d);
        void'(qa.pop_front());
      end else check(q_a_o == '0, "R7", q_a_o, 0);
      ee = wr_at.exists(cyc) && (ea || eb);
      check(err_o == ee, "R9", err_o, ee);
    end
  end

  initial begin
    #(CLK_P * 200000);
    n_err++;
    $display("FAIL R2 watchdog expired");
    report();
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    check(!oe_a_o && !oe_b_o && !err_o, "R10", {oe_a_o, oe_b_o, err_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!oe_a_o && !oe_b_o && !err_o, "R10", {oe_a_o, oe_b_o, err_o}, 0);
    run = 1;
    // clear the array through normal writes
    for (int i = 0; i < (1 << AW); i += 2) step(2, i[AW-1:0], '0, '0, "R1");
    // late writes, R1/R3
    step(2, 6'd4, 9'h011, 9'h022, "R3");
    step(2, 6'd9, 9'h033, 9'h044, "R3");
    step(0, '0, '0, '0, "R5");
    step(1, 6'd4, '0, '0, "R3");
    step(0, '0, '0, '0, "R5");
    step(0, '0, '0, '0, "R5");
    // odd start address: second beat at even partner, R6
    step(1, 6'd9, '0, '0, "R6");
    step(0, '0, '0, '0, "R5");
    step(0, '0, '0, '0, "R5");
    // back-to-back reads, R8
    step(1, 6'd4, '0, '0, "R8");
    step(1, 6'd9, '0, '0, "R8");
    step(1, 6'd5, '0, '0, "R8");
    step(0, '0, '0, '0, "R5");
    step(0, '0, '0, '0, "R5");
    // write then read same address next edge, R11
    step(2, 6'd20, 9'h1a5, 9'h05a, "R11");
    step(1, 6'd20, '0, '0, "R11");
    step(1, 6'd21, '0, '0, "R11");
    step(0, '0, '0, '0, "R5");
    step(0, '0, '0, '0, "R5");
    // read followed by deselect, R4/R5
    step(1, 6'd8, '0, '0, "R4");
    step(0, '0, '0, '0, "R5");
    step(0, '0, '0, '0, "R5");
    step(0, '0, '0, '0, "R5");
    // contention: write right after read (lane B), R9
    step(1, 6'd4, '0, '0, "R4");
    step(2, 6'd30, 9'h0f0, 9'h00f, "R9");
    step(0, '0, '0, '0, "R5");
    step(0, '0, '0, '0, "R5");
    // write one idle after read (lane A), R9
    step(1, 6'd30, '0, '0, "R4");
    step(0, '0, '0, '0, "R5");
    step(2, 6'd40, 9'h123, 9'h0ab, "R9");
    step(0, '0, '0, '0, "R5");
    step(0, '0, '0, '0, "R5");
    // two idles: no contention
    step(1, 6'd40, '0, '0, "R4");
    step(0, '0, '0, '0, "R5");
    step(0, '0, '0, '0, "R5");
    step(2, 6'd50, 9'h1ff, 9'h100, "R9");
    step(0, '0, '0, '0, "R5");
    // sweep of pairs then streamed reads, R2/R6
    for (int i = 0; i < 16; i++)
      step(2, 6'(i * 2 + 1), 9'(i * 7 + 3), 9'(i * 13 + 1), "R1");
    step(0, '0, '0, '0, "R5");
    for (int i = 0; i < 32; i++) step(1, 6'(i), '0, '0, "R2");
    repeat (4) step(0, '0, '0, '0, "R5");
    @(negedge clk);
    check(qa.size() == 0 && qb.size() == 0, "R2", qa.size() + qb.size(), 0);
    report();
  end
endmodule